// File: doc/BRIEF.md
# Multicycle RISC Instruction Sequencer

This block is a small non-pipelined 32-bit processor core. It runs one instruction at a time and moves it through up to five steps: fetch, decode, execute, memory access and write-back. Between the steps it keeps its working values in internal registers: the instruction word, the next sequential address, the two operands, the extended immediate, the ALU result, the branch condition and the loaded data. It handles register-register ALU operations, register-immediate ALU operations, word loads, word stores and a branch taken on equal operands.

Each instruction class takes only as many cycles as it needs. A branch retires after two cycles, a store after four, and every other class after five. The sequencer then goes straight back to fetch. The program is supplied as a parameter array that forms the read-only instruction memory. The data memory is a small internal word array that reset clears. A zero instruction word stops the core, and a combinational debug port then lets the surrounding logic read any general register.

Top module: `mcr_core`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets the PC to 0, clears all 32 general registers and every data memory word, deasserts `halted` and puts the sequencer in the fetch step.
- R2: Word fields: opcode is bits 31:26, rs is 25:21, rt is 20:16, rd is 15:11, funct is 5:0 and the immediate is 15:0. Opcode 0x00 with funct 0x20/0x22/0x24/0x25/0x26/0x2A writes rs+rt, rs-rt, AND, OR, XOR or signed less-than (1 or 0) into rd. It retires in 5 cycles, and the write takes effect at the edge that ends the fifth cycle.
- R3: Opcodes 0x08/0x0A/0x0C/0x0D/0x0E write into rt the value of rs combined with the sign-extended immediate by add, signed less-than, AND, OR or XOR. They retire in 5 cycles.
- R4: A load (opcode 0x23) writes into rt the data word at byte address rs + sign-extended immediate. Bits 5:2 of that address select one of the 16 words. It retires in 5 cycles.
- R5: A store (opcode 0x2B) writes rt into the data word at rs + sign-extended immediate. It changes no register and retires in 4 cycles.
- R6: A branch (opcode 0x04) retires in 2 cycles. If rs equals rt, the next PC is PC + 4 + (sign-extended immediate × 4), so negative offsets go backward. Otherwise the next PC is PC + 4.
- R7: Register 0 always reads as zero, and any write aimed at it is discarded.
- R8: When the fetched word is 0x00000000, `halted` rises after that fetch edge. From then on `halted`, the PC and every register stay unchanged until reset.
- R9: An unrecognised opcode, or opcode 0x00 with an unlisted funct, changes no register or memory word. It retires in 2 cycles with PC + 4.
- R10: `dbg_data` shows general register `dbg_addr` combinationally, with address 0 giving zero.
- R11: Each fetch starts in the cycle after the previous instruction's last cycle. The halt therefore appears exactly one cycle after the sum of the class cycle counts of the instructions executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_addr | input | 5 | General register index for the debug read |
| dbg_data | output | 32 | Contents of the addressed register |
| halted | output | 1 | High once a zero instruction word has been fetched |

## Verification
In one clock cycle the write-back of an instruction can land on the same register that the debug port is reading. The debug port must show the old value until the edge and the new value after it. The bench sweeps the debug address through every register on every cycle, so over the run each write-back cycle meets the read of its target register. A behavioural instruction model fixes which cycle the write becomes visible. The same holds for a branch whose operands were written by the instruction just before it: the branch reads them in its decode cycle, directly after that write-back, and the loop count it produces is checked through the final registers and the halt cycle.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    typedef enum logic [2:0] {
        S_FETCH  = 3'd0,
        S_DECODE = 3'd1,
        S_EXEC   = 3'd2,
        S_MEM    = 3'd3,
        S_WB     = 3'd4,
        S_HALT   = 3'd5
    } seq_state_e;

    typedef enum logic [2:0] {
        C_NOP,
        C_RR,
        C_RI,
        C_LOAD,
        C_STORE,
        C_BRANCH
    } instr_class_e;

    typedef enum logic [2:0] {
        A_ADD,
        A_SUB,
        A_AND,
        A_OR,
        A_XOR,
        A_SLT
    } alu_op_e;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_BEQ     = 6'h04;
    localparam logic [5:0] OPC_ADDI    = 6'h08;
    localparam logic [5:0] OPC_SLTI    = 6'h0A;
    localparam logic [5:0] OPC_ANDI    = 6'h0C;
    localparam logic [5:0] OPC_ORI     = 6'h0D;
    localparam logic [5:0] OPC_XORI    = 6'h0E;
    localparam logic [5:0] OPC_LW      = 6'h23;
    localparam logic [5:0] OPC_SW      = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        seq_state_e  st;
        logic [31:0] pc;
        logic [31:0] ir;
        logic [31:0] npc;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] imm;
        logic [31:0] alu_out;
        logic [31:0] lmd;
        logic        cond;
    } core_state_t;

endpackage

// File: rtl/mcr_regfile.sv
module mcr_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    parameter int NRD   = 3,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr [NRD],
    output logic [W-1:0]  rdata [NRD],
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);

    logic [W-1:0] cells [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) cells[i] <= '0;
        end else if (we && (waddr != '0)) begin
            cells[waddr] <= wdata;
        end
    end

    // register 0 is hard-wired to zero on every read port
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : cells[raddr[g]];
    end

endmodule

// File: rtl/mcr_alu.sv
module mcr_alu
    import mcr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_op_e      op,
    output logic [W-1:0] res
);

    always_comb begin
        unique case (op)
            A_ADD:   res = opa + opb;
            A_SUB:   res = opa - opb;
            A_AND:   res = opa & opb;
            A_OR:    res = opa | opb;
            A_XOR:   res = opa ^ opb;
            A_SLT:   res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: res = opa + opb;
        endcase
    end

endmodule

// File: rtl/mcr_decode.sv
module mcr_decode
    import mcr_pkg::*;
(
    input  logic [5:0]   opcode,
    input  logic [5:0]   funct,
    input  logic [4:0]   rt,
    input  logic [4:0]   rd,
    output instr_class_e cls,
    output alu_op_e      aop,
    output logic [4:0]   dst,
    output logic         dst_we
);

    always_comb begin
        cls = C_NOP;
        aop = A_ADD;
        dst = rt;
        case (opcode)
            OPC_SPECIAL: begin
                dst = rd;
                cls = C_RR;
                case (funct)
                    FN_ADD:  aop = A_ADD;
                    FN_SUB:  aop = A_SUB;
                    FN_AND:  aop = A_AND;
                    FN_OR:   aop = A_OR;
                    FN_XOR:  aop = A_XOR;
                    FN_SLT:  aop = A_SLT;
                    default: cls = C_NOP;
                endcase
            end
            OPC_ADDI: begin cls = C_RI; aop = A_ADD; end
            OPC_SLTI: begin cls = C_RI; aop = A_SLT; end
            OPC_ANDI: begin cls = C_RI; aop = A_AND; end
            OPC_ORI:  begin cls = C_RI; aop = A_OR;  end
            OPC_XORI: begin cls = C_RI; aop = A_XOR; end
            OPC_LW:   begin cls = C_LOAD;  aop = A_ADD; end
            OPC_SW:   begin cls = C_STORE; aop = A_ADD; end
            OPC_BEQ:  begin cls = C_BRANCH; end
            default:  cls = C_NOP;
        endcase
        dst_we = (cls == C_RR) || (cls == C_RI) || (cls == C_LOAD);
    end

endmodule

// File: rtl/mcr_dmem.sv
module mcr_dmem #(
    parameter int WORDS = 16,
    parameter int W     = 32,
    parameter int IW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) words[i] <= '0;
        end else if (we) begin
            words[idx] <= wdata;
        end
    end

    assign rdata = words[idx];

endmodule

// File: rtl/mcr_core.sv
module mcr_core
    import mcr_pkg::*;
#(
    parameter int          IMEM_WORDS = 32,
    parameter int          DMEM_WORDS = 16,
    parameter logic [31:0] PROGRAM [IMEM_WORDS] = '{default: 32'h0}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  dbg_addr,
    output logic [31:0] dbg_data,
    output logic        halted
);

    localparam int IAW    = $clog2(IMEM_WORDS);
    localparam int DIW    = $clog2(DMEM_WORDS);
    localparam int NREGS  = 32;
    localparam int RD_RS  = 0;
    localparam int RD_RT  = 1;
    localparam int RD_DBG = 2;

    core_state_t q, d;

    // instruction memory: read-only array taken from the parameter
    logic [31:0] fetch_word;
    assign fetch_word = PROGRAM[q.pc[IAW+1:2]];

    logic [31:0] sext_imm;
    assign sext_imm = {{16{q.ir[15]}}, q.ir[15:0]};

    // decode of the held instruction word
    instr_class_e cls;
    alu_op_e      aop;
    logic [4:0]   dst;
    logic         dst_we;

    mcr_decode u_dec (
        .opcode (q.ir[31:26]),
        .funct  (q.ir[5:0]),
        .rt     (q.ir[20:16]),
        .rd     (q.ir[15:11]),
        .cls    (cls),
        .aop    (aop),
        .dst    (dst),
        .dst_we (dst_we)
    );

    // register file with two operand ports and the debug port
    logic [4:0]  rf_ra [3];
    logic [31:0] rf_rd [3];
    logic        rf_we;
    logic [31:0] rf_wd;

    assign rf_ra[RD_RS]  = q.ir[25:21];
    assign rf_ra[RD_RT]  = q.ir[20:16];
    assign rf_ra[RD_DBG] = dbg_addr;

    mcr_regfile #(.NREGS(NREGS), .W(32), .NRD(3)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (rf_ra),
        .rdata (rf_rd),
        .we    (rf_we),
        .waddr (dst),
        .wdata (rf_wd)
    );

    // ALU: second operand is B for register-register, Imm otherwise
    logic [31:0] alu_b;
    logic [31:0] alu_y;
    assign alu_b = (cls == C_RR) ? q.b : q.imm;

    mcr_alu #(.W(32)) u_alu (
        .opa (q.a),
        .opb (alu_b),
        .op  (aop),
        .res (alu_y)
    );

    // data memory addressed by the held ALU result
    logic        dm_we;
    logic [31:0] dm_rdata;

    mcr_dmem #(.WORDS(DMEM_WORDS), .W(32)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (q.alu_out[DIW+1:2]),
        .we    (dm_we),
        .wdata (q.b),
        .rdata (dm_rdata)
    );

    logic        br_eq;
    logic [31:0] br_target;
    assign br_eq     = (rf_rd[RD_RS] == rf_rd[RD_RT]);
    assign br_target = q.npc + {sext_imm[29:0], 2'b00};

    always_comb begin
        d     = q;
        rf_we = 1'b0;
        rf_wd = q.alu_out;
        dm_we = 1'b0;
        unique case (q.st)
            S_FETCH: begin
                d.ir  = fetch_word;
                d.npc = q.pc + 32'd4;
                d.st  = (fetch_word == 32'h0) ? S_HALT : S_DECODE;
            end
            S_DECODE: begin
                d.a   = rf_rd[RD_RS];
                d.b   = rf_rd[RD_RT];
                d.imm = sext_imm;
                case (cls)
                    C_BRANCH: begin
                        // the branch resolves here so that it retires in two cycles
                        d.cond    = br_eq;
                        d.alu_out = br_target;
                        d.pc      = br_eq ? br_target : q.npc;
                        d.st      = S_FETCH;
                    end
                    C_NOP: begin
                        d.pc = q.npc;
                        d.st = S_FETCH;
                    end
                    default: d.st = S_EXEC;
                endcase
            end
            S_EXEC: begin
                d.alu_out = alu_y;
                d.st      = S_MEM;
            end
            S_MEM: begin
                if (cls == C_STORE) begin
                    dm_we = 1'b1;
                    d.pc  = q.npc;
                    d.st  = S_FETCH;
                end else begin
                    if (cls == C_LOAD) d.lmd = dm_rdata;
                    d.st = S_WB;
                end
            end
            S_WB: begin
                rf_we = dst_we;
                rf_wd = (cls == C_LOAD) ? q.lmd : q.alu_out;
                d.pc  = q.npc;
                d.st  = S_FETCH;
            end
            S_HALT: d = q;
            default: d.st = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_FETCH;
        end else begin
            q <= d;
        end
    end

    assign dbg_data = rf_rd[RD_DBG];
    assign halted   = (q.st == S_HALT);

endmodule

// File: rtl/mcr_core_chk.sv
module mcr_core_chk
    import mcr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        halted,
    input logic [4:0]  dbg_addr,
    input logic [31:0] dbg_data,
    input seq_state_e  st,
    input logic [5:0]  opcode,
    input logic [31:0] pc
);

    logic in_rst_q;
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_rst_q |-> (pc == 32'h0 && st == S_FETCH && !halted));

    assert_wb_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WB) |=> (st == S_FETCH));

    assert_store_four_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_MEM && opcode == OPC_SW) |=> (st == S_FETCH));

    assert_branch_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DECODE && opcode == OPC_BEQ) |=> (st == S_FETCH));

    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == 5'd0) |-> (dbg_data == 32'h0));

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc)));

endmodule

bind mcr_core mcr_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halted   (halted),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data),
    .st       (q.st),
    .opcode   (q.ir[31:26]),
    .pc       (q.pc)
);

// File: tb/tb_mcr_core.sv
module tb_mcr_core;

    function automatic logic [31:0] enc_r(int rd, int rs, int rt, logic [5:0] fn);
        logic [31:0] w;
        w = {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'h00, fn};
        return w;
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rt, int rs, int imm);
        logic [31:0] w;
        w = {op, rs[4:0], rt[4:0], imm[15:0]};
        return w;
    endfunction

    localparam logic [31:0] PROG [32] = '{
        0:  enc_i(6'h08, 1, 0, 5),          // addi r1 = 5
        1:  enc_i(6'h08, 2, 0, -3),         // addi r2 = -3
        2:  enc_r(3, 1, 2, 6'h20),          // add
        3:  enc_r(4, 2, 1, 6'h22),          // sub
        4:  enc_r(5, 1, 2, 6'h24),          // and
        5:  enc_r(6, 1, 2, 6'h25),          // or
        6:  enc_r(7, 1, 2, 6'h26),          // xor
        7:  enc_r(8, 2, 1, 6'h2A),          // slt
        8:  enc_i(6'h0A, 9, 1, -1),         // slti
        9:  enc_i(6'h0D, 10, 0, 32'h8001),  // ori, sign-extended
        10: enc_i(6'h2B, 1, 0, 8),          // sw r1 -> word 2
        11: enc_i(6'h2B, 4, 3, 10),         // sw r4 -> word 3
        12: enc_i(6'h23, 11, 0, 8),         // lw r11
        13: enc_i(6'h23, 12, 3, 10),        // lw r12
        14: enc_i(6'h08, 0, 1, 7),          // write to r0 discarded
        15: enc_r(13, 0, 1, 6'h20),         // r13 = r0 + r1
        16: enc_i(6'h04, 11, 1, 1),         // beq taken, skips 17
        17: enc_i(6'h08, 14, 0, 99),
        18: enc_i(6'h04, 2, 1, 5),          // beq not taken
        19: enc_r(17, 1, 1, 6'h01),         // unlisted funct
        20: enc_i(6'h08, 15, 15, 1),        // loop body
        21: enc_i(6'h0A, 16, 15, 3),
        22: enc_i(6'h04, 0, 16, 1),         // exit when r16 == 0
        23: enc_i(6'h04, 0, 0, -4),         // back to 20
        default: 32'h0
    };

    logic        clk;
    logic        rst_n;
    logic [4:0]  dbg_addr;
    logic [31:0] dbg_data;
    logic        halted;

    mcr_core #(.IMEM_WORDS(32), .DMEM_WORDS(16), .PROGRAM(PROG)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data),
        .halted   (halted)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // behavioural instruction-level reference model
    logic [31:0] mreg [32];
    logic [31:0] mdmem [16];
    logic [31:0] mpc;
    logic [31:0] mcur;
    int          mleft;
    logic        mhalt;

    function automatic int class_cycles(logic [31:0] w);
        logic [5:0] op;
        logic [5:0] fn;
        op = w[31:26];
        fn = w[5:0];
        if (op == 6'h00)
            return (fn inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A}) ? 5 : 2;
        if (op inside {6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E, 6'h23}) return 5;
        if (op == 6'h2B) return 4;
        return 2;
    endfunction

    task automatic model_exec(logic [31:0] w);
        logic [31:0] rs, rt, si, res, addr;
        logic [5:0]  op;
        int          dst;
        logic        wr;
        op  = w[31:26];
        rs  = mreg[w[25:21]];
        rt  = mreg[w[20:16]];
        si  = {{16{w[15]}}, w[15:0]};
        wr  = 1'b0;
        dst = int'(w[20:16]);
        res = 32'h0;
        mpc = mpc + 32'd4;
        case (op)
            6'h00: begin
                dst = int'(w[15:11]);
                wr  = 1'b1;
                case (w[5:0])
                    6'h20: res = rs + rt;
                    6'h22: res = rs - rt;
                    6'h24: res = rs & rt;
                    6'h25: res = rs | rt;
                    6'h26: res = rs ^ rt;
                    6'h2A: res = ($signed(rs) < $signed(rt)) ? 32'd1 : 32'd0;
                    default: wr = 1'b0;
                endcase
            end
            6'h08: begin res = rs + si; wr = 1'b1; end
            6'h0A: begin res = ($signed(rs) < $signed(si)) ? 32'd1 : 32'd0; wr = 1'b1; end
            6'h0C: begin res = rs & si; wr = 1'b1; end
            6'h0D: begin res = rs | si; wr = 1'b1; end
            6'h0E: begin res = rs ^ si; wr = 1'b1; end
            6'h23: begin addr = rs + si; res = mdmem[addr[5:2]]; wr = 1'b1; end
            6'h2B: begin addr = rs + si; mdmem[addr[5:2]] = rt; end
            6'h04: if (rs == rt) mpc = mpc + {si[29:0], 2'b00};
            default: ;
        endcase
        if (wr && dst != 0) mreg[dst] = res;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
            for (int i = 0; i < 16; i++) mdmem[i] = 32'h0;
            mpc   = 32'h0;
            mcur  = 32'h0;
            mleft = 0;
            mhalt = 1'b0;
        end else if (!mhalt) begin
            if (mleft == 0) begin
                mcur = PROG[mpc[6:2]];
                if (mcur == 32'h0) mhalt = 1'b1;
                else mleft = class_cycles(mcur) - 1;
            end else begin
                mleft--;
                if (mleft == 0) model_exec(mcur);
            end
        end
    end

    task automatic read_reg(int idx, output logic [31:0] val);
        dbg_addr = idx[4:0];
        #1;
        val = dbg_data;
    endtask

    // compare debug read and halt flag to the model every cycle
    task automatic run_to_halt();
        int n;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            dbg_addr = n[4:0];
            #1;
            chk("R10", dbg_data, mreg[n[4:0]], "per-cycle register vs model");
            chk("R8", {31'h0, halted}, {31'h0, mhalt}, "per-cycle halt vs model");
            if (halted || n > 3000) break;
        end
        // 124 instruction cycles plus the halting fetch (R11)
        chk("R11", n, 125, "edges until halt");
    endtask

    task automatic final_checks();
        logic [31:0] v;
        read_reg(3, v);  chk("R2", v, 32'h0000_0002, "add");
        read_reg(4, v);  chk("R2", v, 32'hFFFF_FFF8, "sub");
        read_reg(5, v);  chk("R2", v, 32'h0000_0005, "and");
        read_reg(6, v);  chk("R2", v, 32'hFFFF_FFFD, "or");
        read_reg(7, v);  chk("R2", v, 32'hFFFF_FFF8, "xor");
        read_reg(8, v);  chk("R2", v, 32'h0000_0001, "slt signed");
        read_reg(9, v);  chk("R3", v, 32'h0000_0000, "slti negative imm");
        read_reg(10, v); chk("R3", v, 32'hFFFF_8001, "ori sign-extended");
        read_reg(11, v); chk("R4", v, 32'h0000_0005, "load after store r1");
        read_reg(12, v); chk("R5", v, 32'hFFFF_FFF8, "store with base reg");
        read_reg(0, v);  chk("R7", v, 32'h0, "r0 after write attempt");
        read_reg(13, v); chk("R7", v, 32'h0000_0005, "r0 reads zero as source");
        read_reg(14, v); chk("R6", v, 32'h0, "taken branch skipped word");
        read_reg(15, v); chk("R6", v, 32'h0000_0003, "backward loop count");
        read_reg(16, v); chk("R6", v, 32'h0, "loop exit condition");
        read_reg(17, v); chk("R9", v, 32'h0, "unlisted funct no write");
    endtask

    initial begin
        logic [31:0] v;
        rst_n    = 1'b0;
        dbg_addr = 5'd0;
        repeat (3) @(negedge clk);
        read_reg(3, v);
        chk("R1", v, 32'h0, "register cleared in reset");
        chk("R1", {31'h0, halted}, 32'h0, "halted low in reset");
        rst_n = 1'b1;
        run_to_halt();
        repeat (8) begin
            @(negedge clk);
            chk("R8", {31'h0, halted}, 32'h1, "halt held");
        end
        final_checks();
        // second run: reset must clear the state the first run left behind
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        read_reg(12, v);
        chk("R1", v, 32'h0, "register cleared by later reset");
        chk("R1", {31'h0, halted}, 32'h0, "halt cleared by reset");
        rst_n = 1'b1;
        run_to_halt();
        final_checks();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected halt");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule